// File: doc/BRIEF.md
# Pseudo-Random Noise Voice with Envelope and Length Gate

This block produces one voice of pseudo-random noise for a sound generator. A 15-bit linear feedback shift register steps once per selected number of CPU-rate clock enables. The number of enables comes from a 16-entry period table. A second feedback tap can be selected, which gives a much shorter, more tonal sequence. The register's top bit gates a 4-bit amplitude onto the output. That amplitude is either a fixed volume or a decaying envelope that can restart and loop.

A length counter, loaded from a 32-entry table, silences the voice when it runs out. An external frame sequencer supplies two pulses: quarter-frame pulses step the envelope, and half-frame pulses step the length counter. Software writes three byte-wide registers through a select code. A level enable input clears the length counter and blocks it from loading.

Top module: `noise_voice`

## Requirements
- R1: After a synchronous active-low reset, `level` is 0 and `len_active` is 0. The shift register holds 1, and the envelope, its divider, the length counter, the volume register and the period register are all zero.
- R2: On each step, the shift register shifts right by one. Bit 14 receives bit 0 XOR the tap bit. The tap is bit 1 when bit 7 of the period register is 0, and bit 6 when it is 1.
- R3: The register steps once every N cycles with `cpu_ce` high. N is taken from bits 3:0 of the period register, indices 0 to 15, through the table 4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068.
- R4: A period register write (`wr_sel`=1) limits the running enable count to the new N-1. The next step therefore follows no more than N enables later.
- R5: `level` equals the current amplitude when shift-register bit 14 is 1, and 0 otherwise. It is 0 whenever the length counter is 0.
- R6: A volume register write (`wr_sel`=0) sets three fields. Bits 3:0 are the volume and the envelope divider period. Bit 4 selects constant volume, in which case the amplitude is bits 3:0; otherwise the amplitude is the envelope. Bit 5 sets envelope loop and length halt. A write with `wr_sel`=3 changes nothing.
- R7: A length register write (`wr_sel`=2) sets a restart flag. The next quarter-frame pulse then sets the envelope to 15 and the divider to 0, instead of stepping them.
- R8: Without a pending restart, each quarter-frame pulse advances the divider. When the divider already equals the period, it returns to 0 and clocks the envelope. A clocked envelope decrements if nonzero. At 0 it reloads 15 when loop is set, and otherwise stays at 0.
- R9: A length register write while `chan_en` is high loads the length counter from bits 7:3 through the table 10, 254, 20, 2, 40, 4, 80, 6, 160, 8, 60, 10, 14, 12, 26, 14, 12, 16, 24, 18, 48, 20, 96, 22, 192, 24, 72, 26, 16, 28, 32, 30. While `chan_en` is low, the load has no effect.
- R10: A half-frame pulse decrements a nonzero length counter unless the halt bit is set. `len_active` is 1 exactly when the counter is nonzero.
- R11: While `chan_en` is low, the length counter is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_ce | input | 1 | CPU-rate clock enable for the period timer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 volume, 1 period, 2 length, 3 none |
| wr_data | input | 8 | Write data |
| chan_en | input | 1 | Voice enable level |
| qtr_tick | input | 1 | Quarter-frame pulse, steps the envelope |
| half_tick | input | 1 | Half-frame pulse, steps the length counter |
| level | output | 4 | Noise output amplitude |
| len_active | output | 1 | Length counter is nonzero |

## Verification
All internal state reaches the ports through `level` and `len_active`, so the bench compares both every cycle against a model.

- A wrong tap, shift direction or seed changes the on/off pattern of `level` at the first step that differs. That is at most a few table periods after the fault.
- A timer off by one drifts that pattern by one enable per step, and the sweep over all sixteen periods exposes this within three steps.
- Envelope or divider errors show as a wrong `level` value on the pulse after which the envelope should change.
- A length-table or decrement error shows as `len_active` falling on the wrong half-frame pulse.

// File: rtl/noise_pkg.sv
// Shared constants, register selects and lookup tables for the noise voice.
package noise_pkg;

    localparam int LFSR_W = 15;
    localparam int CNT_W  = 12;
    localparam int LEN_W  = 8;
    localparam int AMP_W  = 4;

    typedef enum logic [1:0] {
        SEL_VOL  = 2'd0,
        SEL_PER  = 2'd1,
        SEL_LEN  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Step period in CPU enables for a 4-bit period index.
    function automatic logic [CNT_W-1:0] period_lookup(input logic [3:0] idx);
        case (idx)
            4'd0:  period_lookup = 12'd4;
            4'd1:  period_lookup = 12'd8;
            4'd2:  period_lookup = 12'd16;
            4'd3:  period_lookup = 12'd32;
            4'd4:  period_lookup = 12'd64;
            4'd5:  period_lookup = 12'd96;
            4'd6:  period_lookup = 12'd128;
            4'd7:  period_lookup = 12'd160;
            4'd8:  period_lookup = 12'd202;
            4'd9:  period_lookup = 12'd254;
            4'd10: period_lookup = 12'd380;
            4'd11: period_lookup = 12'd508;
            4'd12: period_lookup = 12'd762;
            4'd13: period_lookup = 12'd1016;
            4'd14: period_lookup = 12'd2034;
            default: period_lookup = 12'd4068;
        endcase
    endfunction

    // Length counter load value for a 5-bit length index.
    function automatic logic [LEN_W-1:0] length_lookup(input logic [4:0] idx);
        if (idx[0]) begin
            // odd indices: 254 for index 1, otherwise index minus one
            length_lookup = (idx == 5'd1) ? 8'd254 : {3'd0, idx} - 8'd1;
        end else begin
            case (idx[4:1])
                4'd0:  length_lookup = 8'd10;
                4'd1:  length_lookup = 8'd20;
                4'd2:  length_lookup = 8'd40;
                4'd3:  length_lookup = 8'd80;
                4'd4:  length_lookup = 8'd160;
                4'd5:  length_lookup = 8'd60;
                4'd6:  length_lookup = 8'd14;
                4'd7:  length_lookup = 8'd26;
                4'd8:  length_lookup = 8'd12;
                4'd9:  length_lookup = 8'd24;
                4'd10: length_lookup = 8'd48;
                4'd11: length_lookup = 8'd96;
                4'd12: length_lookup = 8'd192;
                4'd13: length_lookup = 8'd72;
                4'd14: length_lookup = 8'd16;
                default: length_lookup = 8'd32;
            endcase
        end
    endfunction

endpackage

// File: rtl/noise_lfsr.sv
// Period timer and shift register of the noise voice.
// Counts CPU enables up to the table period, then shifts the register right
// with XOR feedback into the top bit. Assumes a period write and an enable
// never need to act in the same cycle: the write takes precedence.
module noise_lfsr
    import noise_pkg::*;
#(
    parameter int W         = LFSR_W,
    parameter int LONG_TAP  = 1,
    parameter int SHORT_TAP = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_ce,
    input  logic       per_wr,
    input  logic [3:0] per_idx,
    input  logic       per_short,
    output logic       top_bit
);

    localparam logic [W-1:0] SEED = {{(W-1){1'b0}}, 1'b1};

    logic [3:0]       idx_q;
    logic             short_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     sr_q;
    logic [CNT_W-1:0] cur_last;
    logic [CNT_W-1:0] new_last;
    logic             fb;

    // Last count value of the current and the newly written period.
    always_comb begin
        cur_last = period_lookup(idx_q) - 1'b1;
        new_last = period_lookup(per_idx) - 1'b1;
        fb       = sr_q[0] ^ (short_q ? sr_q[SHORT_TAP] : sr_q[LONG_TAP]);
    end

    // Timer count, period register and shift register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= 4'd0;
            short_q <= 1'b0;
            cnt_q   <= '0;
            sr_q    <= SEED;
        end else if (per_wr) begin
            idx_q   <= per_idx;
            short_q <= per_short;
            if (cnt_q > new_last) cnt_q <= new_last;
        end else if (cpu_ce) begin
            if (cnt_q >= cur_last) begin
                cnt_q <= '0;
                sr_q  <= {fb, sr_q[W-1:1]};
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign top_bit = sr_q[W-1];

    // R2
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != '0);

    // R3
    timer_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cur_last);

    // R2
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ce || per_wr) |=> $stable(sr_q));

endmodule

// File: rtl/noise_envelope.sv
// Volume register and decaying envelope of the noise voice.
// Holds the volume/period, constant-volume and loop fields, steps the envelope
// on quarter-frame pulses and restarts it after a length-register write.
module noise_envelope
    import noise_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qtr,
    input  logic             vol_wr,
    input  logic [5:0]       vol_data,
    input  logic             restart,
    output logic [AMP_W-1:0] amp,
    output logic             halt
);

    localparam logic [AMP_W-1:0] FULL = '1;

    logic [AMP_W-1:0] vol_q;
    logic             const_q;
    logic             loop_q;
    logic [AMP_W-1:0] env_q;
    logic [AMP_W-1:0] div_q;
    logic             flag_q;

    // Volume register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_q   <= '0;
            const_q <= 1'b0;
            loop_q  <= 1'b0;
        end else if (vol_wr) begin
            vol_q   <= vol_data[3:0];
            const_q <= vol_data[4];
            loop_q  <= vol_data[5];
        end
    end

    // Restart flag: raised by a length write, consumed by a quarter pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (restart) flag_q <= 1'b1;
        else if (qtr)     flag_q <= 1'b0;
    end

    // Envelope and divider stepping on quarter-frame pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            env_q <= '0;
            div_q <= '0;
        end else if (qtr) begin
            if (flag_q) begin
                env_q <= FULL;
                div_q <= '0;
            end else if (div_q >= vol_q) begin
                div_q <= '0;
                if (env_q != '0)  env_q <= env_q - 1'b1;
                else if (loop_q)  env_q <= FULL;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign amp  = const_q ? vol_q : env_q;
    assign halt = loop_q;

    // R7
    env_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qtr && flag_q) |=> (env_q == FULL && div_q == '0));

    // R8
    env_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !qtr |=> $stable(env_q));

endmodule

// File: rtl/noise_length.sv
// Length counter of the noise voice.
// Loads from the length table on a write while enabled, counts down on
// half-frame pulses unless halted, and is held at zero while disabled.
module noise_length
    import noise_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_en,
    input  logic       load,
    input  logic [4:0] load_idx,
    input  logic       half,
    input  logic       halt,
    output logic       active
);

    logic [LEN_W-1:0] len_q;

    // Counter load, countdown and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                            len_q <= '0;
        else if (!chan_en)                     len_q <= '0;
        else if (load)                         len_q <= length_lookup(load_idx);
        else if (half && !halt && len_q != '0) len_q <= len_q - 1'b1;
    end

    assign active = (len_q != '0);

    // R11
    len_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !active);

    // R10
    len_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !load && half && !halt && len_q != '0)
        |=> len_q == $past(len_q) - 8'd1);

    // R10
    len_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !load && halt) |=> $stable(len_q));

endmodule

// File: rtl/noise_voice.sv
// Noise voice top: decodes register writes and combines the shift register,
// envelope and length counter into the 4-bit output.
// Assumes quarter/half pulses are one cycle wide and come from a frame sequencer.
module noise_voice
    import noise_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_ce,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       chan_en,
    input  logic       qtr_tick,
    input  logic       half_tick,
    output logic [3:0] level,
    output logic       len_active
);

    logic             vol_wr;
    logic             per_wr;
    logic             len_wr;
    logic             top_bit;
    logic [AMP_W-1:0] amp;
    logic             halt;

    // Register select decode.
    always_comb begin
        vol_wr = wr_en && (wr_sel == SEL_VOL);
        per_wr = wr_en && (wr_sel == SEL_PER);
        len_wr = wr_en && (wr_sel == SEL_LEN);
    end

    noise_lfsr u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_ce    (cpu_ce),
        .per_wr    (per_wr),
        .per_idx   (wr_data[3:0]),
        .per_short (wr_data[7]),
        .top_bit   (top_bit)
    );

    noise_envelope u_env (
        .clk      (clk),
        .rst_n    (rst_n),
        .qtr      (qtr_tick),
        .vol_wr   (vol_wr),
        .vol_data (wr_data[5:0]),
        .restart  (len_wr),
        .amp      (amp),
        .halt     (halt)
    );

    noise_length u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_en  (chan_en),
        .load     (len_wr),
        .load_idx (wr_data[7:3]),
        .half     (half_tick),
        .halt     (halt),
        .active   (len_active)
    );

    // Output gate: amplitude when the top bit is set and length is running.
    assign level = (len_active && top_bit) ? amp : 4'd0;

    // R5
    silent_when_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !len_active |-> level == 4'd0);

endmodule

// File: tb/noise_voice_test.sv
// Bench for noise_voice: sweeps periods, taps, envelope settings and length
// indices against a behavioural model, comparing both outputs every cycle.
module noise_voice_test;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_ce;
    logic       wr_en;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic       chan_en;
    logic       qtr_tick;
    logic       half_tick;
    logic [3:0] level;
    logic       len_active;

    int vectors = 0;
    int fails   = 0;

    // model state
    logic [14:0] m_sr;
    int          m_cnt;
    logic [3:0]  m_pidx;
    logic        m_short;
    logic [3:0]  m_vol;
    logic        m_cv;
    logic        m_loop;
    logic [3:0]  m_env;
    int          m_div;
    logic        m_flag;
    int          m_len;

    noise_voice uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_ce     (cpu_ce),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .chan_en    (chan_en),
        .qtr_tick   (qtr_tick),
        .half_tick  (half_tick),
        .level      (level),
        .len_active (len_active)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int per_of(input logic [3:0] i);
        case (i)
            0: return 4;     1: return 8;     2: return 16;    3: return 32;
            4: return 64;    5: return 96;    6: return 128;   7: return 160;
            8: return 202;   9: return 254;   10: return 380;  11: return 508;
            12: return 762;  13: return 1016; 14: return 2034; default: return 4068;
        endcase
    endfunction

    function automatic int len_of(input logic [4:0] i);
        case (i)
            0: return 10;   1: return 254; 2: return 20;  3: return 2;
            4: return 40;   5: return 4;   6: return 80;  7: return 6;
            8: return 160;  9: return 8;   10: return 60; 11: return 10;
            12: return 14;  13: return 12; 14: return 26; 15: return 14;
            16: return 12;  17: return 16; 18: return 24; 19: return 18;
            20: return 48;  21: return 20; 22: return 96; 23: return 22;
            24: return 192; 25: return 24; 26: return 72; 27: return 26;
            28: return 16;  29: return 28; 30: return 32; default: return 30;
        endcase
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    task automatic model_reset();
        m_sr = 15'd1; m_cnt = 0; m_pidx = 0; m_short = 0;
        m_vol = 0; m_cv = 0; m_loop = 0; m_env = 0; m_div = 0; m_flag = 0; m_len = 0;
    endtask

    task automatic check(input string req);
        logic [3:0] exp_lv;
        logic       exp_act;
        exp_act = (m_len != 0);
        exp_lv  = (exp_act && m_sr[14]) ? (m_cv ? m_vol : m_env) : 4'd0;
        vectors++;
        if (level !== exp_lv || len_active !== exp_act) begin
            fails++;
            $display("FAIL %s: level=%0d len_active=%0b expected level=%0d len_active=%0b",
                     req, level, len_active, exp_lv, exp_act);
        end
    endtask

    // Advance the model by one clock using the currently driven inputs,
    // let the design take the same edge, then compare at the falling edge.
    task automatic step(input string req);
        logic fb;
        bit vw, pw, lw;
        vw = wr_en && wr_sel == 2'd0;
        pw = wr_en && wr_sel == 2'd1;
        lw = wr_en && wr_sel == 2'd2;
        if (!rst_n) model_reset();
        else begin
            // envelope (old register values)
            if (qtr_tick) begin
                if (m_flag) begin m_env = 15; m_div = 0; end
                else if (m_div + 1 > m_vol) begin
                    m_div = 0;
                    if (m_env != 0) m_env = m_env - 1;
                    else if (m_loop) m_env = 15;
                end else m_div = m_div + 1;
            end
            if (lw) m_flag = 1; else if (qtr_tick) m_flag = 0;
            // length
            if (!chan_en) m_len = 0;
            else if (lw) m_len = len_of(wr_data[7:3]);
            else if (half_tick && !m_loop && m_len > 0) m_len = m_len - 1;
            // timer and shift register
            if (pw) begin
                m_pidx = wr_data[3:0]; m_short = wr_data[7];
                if (m_cnt > per_of(m_pidx) - 1) m_cnt = per_of(m_pidx) - 1;
            end else if (cpu_ce) begin
                if (m_cnt + 1 == per_of(m_pidx)) begin
                    m_cnt = 0;
                    fb = m_sr[0] ^ (m_short ? m_sr[6] : m_sr[1]);
                    m_sr = {fb, m_sr[14:1]};
                end else m_cnt = m_cnt + 1;
            end
            if (vw) begin m_vol = wr_data[3:0]; m_cv = wr_data[4]; m_loop = wr_data[5]; end
        end
        @(posedge clk);
        @(negedge clk);
        check(req);
    endtask

    task automatic idle();
        wr_en = 0; wr_sel = 2'd3; wr_data = 8'h00; cpu_ce = 0; qtr_tick = 0; half_tick = 0;
    endtask

    task automatic write(input logic [1:0] sel, input logic [7:0] d, input string req);
        idle();
        wr_en = 1; wr_sel = sel; wr_data = d;
        step(req);
        idle();
    endtask

    task automatic run_ce(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            idle(); cpu_ce = 1; step(req);
        end
        idle();
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R1..all): cycles=200000 expected completion earlier");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        idle(); chan_en = 0; rst_n = 0;
        @(negedge clk);
        step("R1"); step("R1");
        rst_n = 1;
        step("R1");
        run_ce(20, "R1");     // length 0 keeps output silent

        // constant volume 15, long length, then sweep all periods and both taps
        chan_en = 1;
        write(2'd0, 8'h1F, "R6");
        write(2'd2, 8'h08, "R9");
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 16; p++) begin
                write(2'd1, {s[0], 3'b000, p[3:0]}, "R4");
                run_ce(3 * per_of(p[3:0]) + 5, "R2/R3");
            end
        end
        // clamp: long period, partial count, then shortest period
        write(2'd1, 8'h0F, "R4");
        run_ce(3000, "R4");
        write(2'd1, 8'h00, "R4");
        run_ce(9, "R4");
        // gated enables
        for (int i = 0; i < 40; i++) begin
            idle(); cpu_ce = i[0]; step("R3");
        end

        // envelope: periods 0..3, without and with loop
        for (int lp = 0; lp < 2; lp++) begin
            for (int p = 0; p < 4; p++) begin
                write(2'd0, {2'b00, lp[0], 1'b0, p[3:0]}, "R6");
                write(2'd2, 8'h08, "R7");
                for (int q = 0; q < 40; q++) begin
                    idle(); qtr_tick = 1; step("R7/R8");
                    run_ce(3, "R5/R8");
                end
            end
        end

        // length sweep: every index counts down to zero
        write(2'd0, 8'h15, "R6");
        for (int li = 0; li < 32; li++) begin
            write(2'd2, {li[4:0], 3'b000}, "R9");
            for (int h = 0; h < len_of(li[4:0]) + 2; h++) begin
                idle(); half_tick = 1; step("R10");
                run_ce(1, "R5/R10");
            end
        end

        // halt bit stops the countdown
        write(2'd0, 8'h35, "R6");
        write(2'd2, 8'h18, "R9");
        for (int h = 0; h < 6; h++) begin
            idle(); half_tick = 1; step("R10");
            run_ce(2, "R10");
        end
        // unselected write has no effect
        write(2'd3, 8'hFF, "R6");
        run_ce(8, "R6");
        // disable clears, loads while disabled ignored
        chan_en = 0;
        step("R11");
        write(2'd2, 8'h08, "R9");
        run_ce(6, "R9/R11");
        chan_en = 1;
        write(2'd2, 8'h08, "R9");
        run_ce(12, "R9");

        summary();
        $finish;
    end

endmodule